// File: doc/BRIEF.md
# Operand Hazard Interlock

This block watches the instruction sitting in decode of a scalar, in-order, five-stage pipeline. The pipeline has an eight-entry register file. The block compares both source register numbers of that instruction against the destinations of the three older instructions still in flight. For each ALU operand it picks where the operand should come from once the instruction reaches execute: the register file, the result captured after execute, or the result captured after memory access. The youngest matching producer always wins.

When no bypass path can deliver the value in time, the block raises a hold. That happens for a load directly ahead of its consumer, and for a producer that is only about to write back. The hold freezes the program counter and the fetch/decode register, and a second output injects a nop into execute. The block is purely combinational, so its results belong to the same cycle as the inputs that cause them.

A parameter selects whether the register file already passes a same-cycle write through to its read ports. By default it does not, so a producer found only in the write-back slot costs one hold cycle.

Top module: `hazard_interlock`

## Requirements
- R1: With no enabled older writer whose destination equals a source, that source's select is 00 (register file) and there is no hold.
- R2: A source that matches the enabled, non-load instruction in ID/EX gets select 01 (value from EX/MEM when the consumer executes) and causes no hold.
- R3: A source that matches the enabled instruction in EX/MEM, but not the one in ID/EX, gets select 10 (value from MEM/WB) and causes no hold.
- R4: When several older instructions write the same register, the youngest match sets the select: ID/EX over EX/MEM over MEM/WB.
- R5: A stage whose write-enable is low never counts as a match, whatever its destination number.
- R6: A source that matches a load in ID/EX raises `stall` and `bubble`, and while held both selects read 00.
- R7: A load in ID/EX whose destination matches neither source causes no hold.
- R8: With the default parameter (no write-through), a source whose only match is in MEM/WB raises a one-cycle hold. A younger match removes that hold.
- R9: `bubble` is high exactly when `stall` is high.
- R10: Each source is resolved on its own. The two selects may differ, and equal sources get equal selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcA | input | 3 | First source register of the decoding instruction |
| srcB | input | 3 | Second source register of the decoding instruction |
| exRd | input | 3 | Destination held in ID/EX |
| exWen | input | 1 | Register-write enable held in ID/EX |
| exIsLoad | input | 1 | The ID/EX instruction is a load |
| memRd | input | 3 | Destination held in EX/MEM |
| memWen | input | 1 | Register-write enable held in EX/MEM |
| wbRd | input | 3 | Destination held in MEM/WB |
| wbWen | input | 1 | Register-write enable held in MEM/WB |
| fwdSelA | output | 2 | Bypass select for the first ALU input |
| fwdSelB | output | 2 | Bypass select for the second ALU input |
| stall | output | 1 | Freeze PC and IF/ID |
| bubble | output | 1 | Insert a nop into execute |

## Verification
Every output is combinational, so each select and the hold are due in the same cycle as the register numbers and enables that produce them, with zero register delay. The bench changes inputs on the falling clock edge and samples one nanosecond later, well before the next rising edge. At that point it compares all four outputs against a behavioural model that scans the older stages from youngest to oldest. Directed vectors cover the priority, load and write-back corners. A random phase then checks the same model on every clock.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwdSel_e;

  // per-source comparison result, one bit per older stage
  typedef struct packed {
    logic ex;
    logic mem;
    logic wb;
  } srcHits_t;

endpackage

// File: rtl/hazard_cmp.sv
module hazard_cmp
  import hazard_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] srcRegs,
  input  logic [REG_W-1:0]              exRd,
  input  logic                          exWen,
  input  logic [REG_W-1:0]              memRd,
  input  logic                          memWen,
  input  logic [REG_W-1:0]              wbRd,
  input  logic                          wbWen,
  output srcHits_t [NUM_SRC-1:0]        hits
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hits[i].ex  = exWen  && (exRd  == srcRegs[i]);
    assign hits[i].mem = memWen && (memRd == srcRegs[i]);
    assign hits[i].wb  = wbWen  && (wbRd  == srcRegs[i]);
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int NUM_SRC  = 2,
  parameter bit WB_IN_RF = 1'b0
) (
  input  srcHits_t [NUM_SRC-1:0] hits,
  input  logic                   exIsLoad,
  output fwdSel_e  [NUM_SRC-1:0] sel,
  output logic                   stall,
  output logic                   bubble
);

  logic [NUM_SRC-1:0] needWait;
  logic [NUM_SRC-1:0] needNop;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic loadUse;
    logic wbLate;

    assign loadUse = hits[i].ex && exIsLoad;

    if (WB_IN_RF) begin : g_wt
      assign wbLate = 1'b0;
    end else begin : g_nowt
      assign wbLate = hits[i].wb && !hits[i].ex && !hits[i].mem;
    end

    assign needWait[i] = loadUse || wbLate;
    assign needNop[i]  = loadUse || wbLate;

    always_comb begin
      if (stall)            sel[i] = SEL_RF;
      else if (hits[i].ex)  sel[i] = SEL_EXMEM;
      else if (hits[i].mem) sel[i] = SEL_MEMWB;
      else                  sel[i] = SEL_RF;
    end

    always_comb begin
      if (!(hits[i].ex || hits[i].mem || hits[i].wb))
        assert_rf_when_quiet_R1: assert (sel[i] == SEL_RF);
      if (sel[i] == SEL_EXMEM)
        assert_exmem_has_hit_R2: assert (hits[i].ex && !stall);
      if (sel[i] == SEL_MEMWB)
        assert_memwb_youngest_R4: assert (hits[i].mem && !hits[i].ex);
      if (hits[i].ex && exIsLoad)
        assert_load_use_holds_R6: assert (stall && bubble && sel[i] == SEL_RF);
    end
  end

  assign stall  = |needWait;
  assign bubble = |needNop;

  always_comb begin
    assert_hold_pair_R9: assert (stall == bubble);
  end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hazard_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter bit WB_IN_RF  = 1'b0
) (
  input  logic [$clog2(REG_COUNT)-1:0] srcA,
  input  logic [$clog2(REG_COUNT)-1:0] srcB,
  input  logic [$clog2(REG_COUNT)-1:0] exRd,
  input  logic                         exWen,
  input  logic                         exIsLoad,
  input  logic [$clog2(REG_COUNT)-1:0] memRd,
  input  logic                         memWen,
  input  logic [$clog2(REG_COUNT)-1:0] wbRd,
  input  logic                         wbWen,
  output logic [1:0]                   fwdSelA,
  output logic [1:0]                   fwdSelB,
  output logic                         stall,
  output logic                         bubble
);

  localparam int REG_W   = $clog2(REG_COUNT);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] srcRegs;
  srcHits_t [NUM_SRC-1:0]        hits;
  fwdSel_e  [NUM_SRC-1:0]        sel;

  assign srcRegs[0] = srcA;
  assign srcRegs[1] = srcB;

  hazard_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_cmp (
    .srcRegs (srcRegs),
    .exRd    (exRd),
    .exWen   (exWen),
    .memRd   (memRd),
    .memWen  (memWen),
    .wbRd    (wbRd),
    .wbWen   (wbWen),
    .hits    (hits)
  );

  hazard_ctrl #(.NUM_SRC(NUM_SRC), .WB_IN_RF(WB_IN_RF)) u_ctrl (
    .hits     (hits),
    .exIsLoad (exIsLoad),
    .sel      (sel),
    .stall    (stall),
    .bubble   (bubble)
  );

  assign fwdSelA = sel[0];
  assign fwdSelB = sel[1];

endmodule

// File: tb/hazard_interlock_tb.sv
`timescale 1ns/1ps
module hazard_interlock_tb;

  localparam real HALF = 2.0;

  logic       clk = 1'b0;
  logic [2:0] srcA = '0, srcB = '0, exRd = '0, memRd = '0, wbRd = '0;
  logic       exWen = 1'b0, exIsLoad = 1'b0, memWen = 1'b0, wbWen = 1'b0;
  logic [1:0] fwdSelA, fwdSelB;
  logic       stall, bubble;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(HALF) clk = ~clk;

  hazard_interlock u_dut (
    .srcA(srcA), .srcB(srcB), .exRd(exRd), .exWen(exWen), .exIsLoad(exIsLoad),
    .memRd(memRd), .memWen(memWen), .wbRd(wbRd), .wbWen(wbWen),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .stall(stall), .bubble(bubble)
  );

  // reference: scan older stages youngest first (index 0 = ID/EX)
  function automatic void model(input int s, output int selOut, output bit hold);
    int rdQ[3];
    bit wenQ[3];
    int first = -1;
    rdQ  = '{int'(exRd), int'(memRd), int'(wbRd)};
    wenQ = '{exWen, memWen, wbWen};
    for (int k = 0; k < 3; k++)
      if (first < 0 && wenQ[k] && rdQ[k] == s) first = k;
    hold   = (first == 0 && exIsLoad) || (first == 2);
    selOut = (first == 0) ? 1 : (first == 1) ? 2 : 0;
  endfunction

  task automatic expectVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int sa, sb, es, eb;
    bit ha, hb, eh;
    model(int'(srcA), sa, ha);
    model(int'(srcB), sb, hb);
    eh = ha || hb;
    es = eh ? 0 : sa;
    eb = eh ? 0 : sb;
    expectVal(tag, "fwdSelA", int'(fwdSelA), es);
    expectVal(tag, "fwdSelB", int'(fwdSelB), eb);
    expectVal(tag, "stall", int'(stall), int'(eh));
    expectVal("R9", "bubble", int'(bubble), int'(eh));
  endtask

  task automatic apply(input int a, input int b,
                       input int er, input bit ew, input bit ld,
                       input int mr, input bit mw,
                       input int wr, input bit ww);
    @(negedge clk);
    srcA = 3'(a); srcB = 3'(b);
    exRd = 3'(er); exWen = ew; exIsLoad = ld;
    memRd = 3'(mr); memWen = mw;
    wbRd = 3'(wr); wbWen = ww;
    #1;
  endtask

  initial begin
    // idle state: nothing in flight
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    checkAll("R1");
    expectVal("R1", "idle stall", int'(stall), 0);
    // R2: ID/EX producer -> 01
    apply(3, 4, 3, 1, 0, 0, 0, 0, 0);
    checkAll("R2");
    expectVal("R2", "fwdSelA", int'(fwdSelA), 1);
    // R3: EX/MEM producer -> 10
    apply(1, 5, 0, 0, 0, 5, 1, 0, 0);
    checkAll("R3");
    expectVal("R3", "fwdSelB", int'(fwdSelB), 2);
    // R4: youngest wins
    apply(2, 0, 2, 1, 0, 2, 1, 2, 1);
    checkAll("R4");
    expectVal("R4", "fwdSelA", int'(fwdSelA), 1);
    // R5: disabled writers ignored
    apply(6, 6, 6, 0, 0, 6, 0, 6, 0);
    checkAll("R5");
    expectVal("R5", "fwdSelA", int'(fwdSelA), 0);
    expectVal("R5", "stall", int'(stall), 0);
    // R6: load-use hold
    apply(1, 1, 1, 1, 1, 1, 1, 0, 0);
    checkAll("R6");
    expectVal("R6", "stall", int'(stall), 1);
    expectVal("R6", "fwdSelB", int'(fwdSelB), 0);
    // R7: unrelated load
    apply(2, 3, 1, 1, 1, 0, 0, 0, 0);
    checkAll("R7");
    expectVal("R7", "stall", int'(stall), 0);
    // R8: write-back-only producer holds
    apply(7, 0, 0, 0, 0, 0, 0, 7, 1);
    checkAll("R8");
    expectVal("R8", "stall", int'(stall), 1);
    // R8: younger match removes the hold
    apply(7, 0, 0, 0, 0, 7, 1, 7, 1);
    checkAll("R8");
    expectVal("R8", "fwdSelA", int'(fwdSelA), 2);
    // R10: independent sources
    apply(3, 4, 3, 1, 0, 4, 1, 0, 0);
    checkAll("R10");
    expectVal("R10", "fwdSelB", int'(fwdSelB), 2);
    apply(5, 5, 0, 0, 0, 5, 1, 0, 0);
    checkAll("R10");
    expectVal("R10", "equal sel", int'(fwdSelA), int'(fwdSelB));
    // random phase, compared every clock
    for (int n = 0; n < 400; n++) begin
      apply($urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 7), 1'($urandom), 1'($urandom),
            $urandom_range(0, 7), 1'($urandom),
            $urandom_range(0, 7), 1'($urandom));
      checkAll("R4");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule